// File: doc/BRIEF.md
# Programmable Up/Down Counter-Timer Channel

This block is one counter/timer channel steered by an 8-bit command word written over a small register bus. In event-count mode the counter steps once per qualified rising edge of the selected event input and wraps at either end. Each wrap gives a one-cycle terminal pulse and flips an output waveform. In capture mode the counter steps on every clock, and a qualified event edge copies the running value into a capture register and raises a sticky flag. The two polarity bits invert the event input and the waveform output.

Counting starts only after a global start strobe. Each of the following comes from either a synchronized external pin or an already-synchronous internal source: the event input, and the gate that can hold counting. While the channel is enabled, the configuration is frozen, so a new configuration takes three writes: disable, rewrite, re-enable. A watchdog-mode input takes over the channel and makes it count down on every clock, whatever the command word holds.

Bus map: address 0 is the command word. Address 1 holds the preload on write and returns the count on read. A write to address 2 requests a load, and a read of address 2 returns the capture value. A read of address 3 returns the capture flag in bit 0. Read data is registered and appears one cycle after `rd_en`.

Top module: `ctu_channel`

## Requirements
- R1: After reset the command word, count, capture flag, `tc_pulse` and `wave_out` are all 0.
- R2: Command bit 2 is the enable. While it is 1, a write to address 0 updates only bit 2, and bits 7..3 and 1..0 keep their value. While it is 0, a write updates all eight bits. Address 0 reads the command word, zero-extended.
- R3: The counter holds its value until a one-cycle `start` pulse has been seen. After that, counting happens only while bit 2 is 1.
- R4: With bit 0 = 0 (event-count mode), each rising edge of the event input XOR bit 4 moves the count by one. Bit 1 = 1 counts up and bit 1 = 0 counts down.
- R5: In event-count mode, a step up from all-ones or down from 0 wraps around. A wrap makes `tc_pulse` high for exactly one cycle and toggles an internal waveform bit. `wave_out` equals that bit XOR bit 3.
- R6: With bit 0 = 1 (capture mode), the count steps every clock. A qualified event rising edge stores the count value from before that step into the capture register, which is read at address 2, and sets the capture flag. No `tc_pulse` is produced in this mode.
- R7: The capture flag stays set until address 3 is read. That read returns 1 and clears the flag.
- R8: With bit 7 = 1, counting happens only in cycles where the selected gate input is high.
- R9: Bit 5 = 1 selects `pin_evt`/`pin_gate`, which pass through two synchronizer flops. Bit 5 = 0 selects `mc_evt`/`mc_gate`, which are used directly, and the unselected pair is ignored.
- R10: A write to address 2 copies the preload into the count when bit 6 = 1. When bit 6 = 0 the write is ignored.
- R11: While `wdog` is 1 and the channel has been started, the count decrements on every clock. Loads are accepted whatever bit 6 is, and `wave_out` ignores bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| start | input | 1 | Global start strobe |
| wdog | input | 1 | Watchdog-mode override |
| pin_evt | input | 1 | Asynchronous external event input |
| pin_gate | input | 1 | Asynchronous external gate input |
| mc_evt | input | 1 | Synchronous internal event input |
| mc_gate | input | 1 | Synchronous internal gate input |
| wave_out | output | 1 | Output waveform after polarity |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
A bad count shows up on the next read of address 1 or 2, one cycle after `rd_en`. A wrong wrap decision shows up on `tc_pulse` and `wave_out` in the cycle right after the stepping edge. A command word that takes locked bits while enabled shows up on the next read of address 0, and it also changes later counting direction or polarity. Pin-path latency is checked cycle-exactly: a pin edge must not have moved the count two edges after it changes, and must have moved it by the third.

// File: rtl/ctu_channel.sv
module ctu_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             start,
  input  logic             wdog,
  input  logic             pin_evt,
  input  logic             pin_gate,
  input  logic             mc_evt,
  input  logic             mc_gate,
  output logic             wave_out,
  output logic             tc_pulse
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [7:0]       cmd;
  logic [CNT_W-1:0] cnt, pre, cap;
  logic             armed, flag, wave, evt_prev;
  logic [1:0]       pe_s, pg_s;

  logic evt_raw, gate_raw, evt_q, evt_rise, run, step, up, at_end;
  logic load, tc_ev, cap_ev, rd_clr, cmd_wr;

  assign evt_raw  = cmd[5] ? pe_s[1] : mc_evt;
  assign gate_raw = cmd[5] ? pg_s[1] : mc_gate;
  assign evt_q    = evt_raw ^ cmd[4];
  assign evt_rise = evt_q & ~evt_prev;

  assign run    = armed & cmd[2] & (~cmd[7] | gate_raw);
  assign step   = wdog ? armed : (run & (cmd[0] | evt_rise));
  assign up     = ~wdog & cmd[1];
  assign at_end = up ? (cnt == ALL_ONES) : (cnt == '0);

  assign load   = wr_en & (addr == 2'd2) & (wdog | cmd[6]);
  assign tc_ev  = step & at_end & ~load & (wdog | ~cmd[0]);
  assign cap_ev = ~wdog & run & cmd[0] & evt_rise;
  assign rd_clr = rd_en & (addr == 2'd3);
  assign cmd_wr = wr_en & (addr == 2'd0);

  assign wave_out = wave ^ (cmd[3] & ~wdog);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_s     <= '0;
      pg_s     <= '0;
      evt_prev <= 1'b0;
    end else begin
      pe_s     <= {pe_s[0], pin_evt};
      pg_s     <= {pg_s[0], pin_gate};
      evt_prev <= evt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd   <= '0;
      pre   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= armed | start;
      if (wr_en && addr == 2'd1) pre <= wdata;
      if (cmd_wr) begin
        if (cmd[2]) cmd[2] <= wdata[2];
        else        cmd    <= wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cap      <= '0;
      flag     <= 1'b0;
      wave     <= 1'b0;
      tc_pulse <= 1'b0;
    end else begin
      if (load)      cnt <= pre;
      else if (step) cnt <= up ? cnt + 1'b1 : cnt - 1'b1;
      tc_pulse <= tc_ev;
      if (tc_ev) wave <= ~wave;
      if (cap_ev) begin
        cap  <= cnt;
        flag <= 1'b1;
      end else if (rd_clr) begin
        flag <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        2'd0:    rdata <= CNT_W'(cmd);
        2'd1:    rdata <= cnt;
        2'd2:    rdata <= cap;
        default: rdata <= CNT_W'(flag);
      endcase
    end
  end
endmodule

// File: rtl/ctu_channel_chk.sv
module ctu_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic [7:0]       cmd,
  input logic [CNT_W-1:0] cnt,
  input logic             load,
  input logic             wave,
  input logic             tc_pulse,
  input logic             flag,
  input logic             cap_ev,
  input logic             rd_clr,
  input logic             wdog
);
  assert_locked_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd[2]) && cmd[2]) |-> (cmd[7:3] == $past(cmd[7:3]) && cmd[1:0] == $past(cmd[1:0])));

  assert_idle_before_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !load) |=> $stable(cnt));

  assert_tc_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  assert_tc_toggles_wave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (wave != $past(wave)));

  assert_capture_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> flag);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !rd_clr) |=> flag);

  assert_wdog_counts_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog && armed && !load) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

bind ctu_channel ctu_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .cmd(cmd), .cnt(cnt), .load(load),
  .wave(wave), .tc_pulse(tc_pulse), .flag(flag), .cap_ev(cap_ev),
  .rd_clr(rd_clr), .wdog(wdog)
);

// File: tb/ctu_channel_bench.sv
`timescale 1ns/100ps
module ctu_channel_bench;
  logic        clk = 0, rst_n = 0;
  logic        wr_en = 0, rd_en = 0, start = 0, wdog = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        pin_evt = 0, pin_gate = 0, mc_evt = 0, mc_gate = 0;
  logic        wave_out, tc_pulse;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 0;

  always #2.5 clk = ~clk;

  ctu_channel #(.CNT_W(16)) u_ctu_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .start(start), .wdog(wdog),
    .pin_evt(pin_evt), .pin_gate(pin_gate), .mc_evt(mc_evt), .mc_gate(mc_gate),
    .wave_out(wave_out), .tc_pulse(tc_pulse)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) if (rd_seen) begin
    if (exp_q.size() == 0) chk(rdata, 16'hxxxx, "scoreboard underflow");
    else chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic inv_pulse();
    mc_evt = 1; @(negedge clk);
    mc_evt = 0; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tc_pulse, 0, "R1 tc after reset");
    chk(wave_out, 0, "R1 wave after reset");
    rd(0, 16'h0000, "R1 cmd reset");
    rd(1, 16'h0000, "R1 count reset");
    rd(3, 16'h0000, "R1 flag reset");

    wr(0, 16'h0004);
    for (int i = 0; i < 3; i++) begin
      mc_evt = 1; @(negedge clk); mc_evt = 0; @(negedge clk);
    end
    rd(1, 16'h0000, "R3 no count before start");

    wr(0, 16'h00FF); rd(0, 16'h0004, "R2 locked write");
    wr(0, 16'h0000); rd(0, 16'h0000, "R2 disable");
    wr(0, 16'h0012); rd(0, 16'h0012, "R2 rewrite");
    wr(0, 16'h0016); rd(0, 16'h0016, "R2 re-enable");

    start = 1; @(negedge clk); start = 0;
    for (int i = 0; i < 3; i++) inv_pulse();
    rd(1, 16'h0003, "R4 up count inverted input");

    wr(1, 16'hFFFE); wr(2, 0);
    rd(1, 16'h0003, "R10 load ignored bit6=0");
    wr(0, 16'h0012); wr(0, 16'h0052); wr(0, 16'h0056);
    wr(2, 0);
    rd(1, 16'hFFFE, "R10 load accepted");

    inv_pulse();
    chk(tc_pulse, 0, "R5 no tc before wrap");
    inv_pulse();
    chk(tc_pulse, 1, "R5 tc on up wrap");
    chk(wave_out, 1, "R5 wave toggled");
    @(negedge clk);
    chk(tc_pulse, 0, "R5 tc one cycle");
    rd(1, 16'h0000, "R5 wrapped to zero");
    wr(0, 16'h0052); wr(0, 16'h005A); wr(0, 16'h005E);
    chk(wave_out, 0, "R5 output polarity");

    wr(0, 16'h005A); wr(0, 16'h0000); wr(0, 16'h0004);
    chk(wave_out, 1, "R5 polarity cleared");
    mc_evt = 1; @(negedge clk);
    chk(tc_pulse, 1, "R5 tc on down wrap");
    chk(wave_out, 0, "R5 wave toggled back");
    mc_evt = 0;
    rd(1, 16'hFFFF, "R4 down count wraps");

    wr(0, 16'h0000); wr(0, 16'h0043); wr(0, 16'h0047);
    wr(1, 16'd100); wr(2, 0);
    @(negedge clk);
    mc_evt = 1; @(negedge clk);
    rd(2, 16'd101, "R6 capture value");
    rd(3, 16'h0001, "R7 flag set");
    rd(3, 16'h0000, "R7 flag cleared by read");

    wr(0, 16'h0043); wr(0, 16'h00C3); wr(0, 16'h00C7);
    wr(1, 16'd500); wr(2, 0);
    repeat (10) @(negedge clk);
    rd(1, 16'd500, "R8 gate low holds");
    mc_gate = 1; repeat (5) @(negedge clk); mc_gate = 0;
    rd(1, 16'd505, "R8 gate high counts");
    rd(3, 16'h0000, "R6 no capture without edge");

    wr(0, 16'h00C3); wr(0, 16'h006A);
    wr(1, 16'd10); wr(2, 0); wr(0, 16'h006E);
    chk(wave_out, 1, "R5 output polarity set");
    for (int i = 0; i < 2; i++) begin
      mc_evt = 0; @(negedge clk); mc_evt = 1; @(negedge clk);
    end
    rd(1, 16'd10, "R9 internal event ignored");
    pin_evt = 1; @(negedge clk); @(negedge clk);
    rd(1, 16'd10, "R9 two-flop latency");
    rd(1, 16'd11, "R9 pin edge counted");

    wdog = 1; @(negedge clk);
    chk(wave_out, 0, "R11 polarity ignored");
    wr(1, 16'd3); wr(2, 0);
    repeat (4) @(negedge clk);
    chk(tc_pulse, 1, "R11 down wrap tc");
    chk(wave_out, 1, "R11 wave toggled");
    @(negedge clk);
    chk(tc_pulse, 0, "R11 tc one cycle");
    rd(1, 16'hFFFE, "R11 counting down each clock");

    @(negedge clk);
    chk(16'(exp_q.size()), 0, "scoreboard drained");
    finish_run();
  end
endmodule